// File: doc/BRIEF.md
# Radio Interrupt Aggregation Controller

This block merges the event flags of a packet radio into a single interrupt request pin. Event sources fall into three groups: four transmit events, eight receive events spread over two deserializer lanes (A and B, four each), and one wake event. The wake event marks that the crystal oscillator has come up after power-down was released. Every source has a sticky status bit and an enable bit. Both sit behind a simple single-cycle register read/write port. Reading a status register returns its contents and clears it.

The current radio direction decides which groups reach the pin. Transmit operation hides the receive group and receive operation hides the transmit group. The wake event is never hidden by direction, and mode changes leave the stored enables as they were. Two chip-rate modes use only lane A, so lane B is silenced in them. A configuration bit picks the pin polarity. The pin is modelled as a level plus a drive-enable, so a board can wire it as open drain (active low) or open source (active high).

Top module: `radio_irq_agg`

## Requirements
- R1: Register map, 8-bit data: 0x05 config (bit 0 = active-high select), 0x07 receive enable (bits 3:0 lane A, bits 7:4 lane B), 0x08 receive status (same layout), 0x0D transmit enable (bits 3:0), 0x0E transmit status (bits 3:0), 0x1C wake enable (bit 0), 0x1D wake status (bit 0). A write lands on the next rising edge. A read strobe in one cycle presents the data on `reg_rdata` after that edge. Unimplemented bits and unmapped addresses read 0.
- R2: A one-cycle event pulse sets its status bit whether or not the bit is enabled. Reading a status register clears it. An event that arrives in the same cycle as the read keeps its bit set.
- R3: The request is active exactly when an enabled status bit is set and its group is not masked. `tx_mode`=1 masks every receive bit and `tx_mode`=0 masks every transmit bit. The request drops in the cycle after the last such bit clears.
- R4: Changing `tx_mode` never alters the stored enable or config registers. Those change only through writes.
- R5: `chip_mode` 1 (64 chips per bit) and 2 (32 chips per bit, double data rate) block lane B. Lane B events then set no status, and lane B status raises no request. Modes 0 and 3 treat lane B like lane A.
- R6: The wake status sets when `osc_ready` rises while `pd_n` is high. A rise while `pd_n` is low is ignored.
- R7: Reading 0x1D returns the wake status and clears it.
- R8: While the request is active, `irq_oe`=1 and `irq_data` equals config bit 0 (0 = active low, 1 = active high). While it is idle, `irq_oe`=0.
- R9: Writes to 0x08, 0x0E and 0x1D have no effect on the status bits.
- R10: After reset, all enables, statuses and config are 0 and `irq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| tx_evt | input | 4 | Transmit event pulses |
| rx_evt_a | input | 4 | Lane A receive event pulses |
| rx_evt_b | input | 4 | Lane B receive event pulses |
| tx_mode | input | 1 | 1 = transmitting, 0 = receiving |
| chip_mode | input | 2 | Chip-rate mode code |
| pd_n | input | 1 | Power-down release, high = running |
| osc_ready | input | 1 | Oscillator running indication |
| irq_data | output | 1 | Pin level when driven |
| irq_oe | output | 1 | Pin drive-enable |

## Verification
The properties assume that every event input, mode input and register strobe is synchronous to `clk` and changes only between rising edges. They also assume that event inputs are single-cycle pulses that the register port cannot race except in the stated same-cycle read case. The bench drives every input on the falling edge and returns events to zero after one cycle. It changes `tx_mode`, `chip_mode`, `pd_n` and `osc_ready` only while no register access is in flight, so each check samples a state that one known edge produced.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] A_CFG   = 6'h05;
  localparam logic [REG_AW-1:0] A_RX_EN = 6'h07;
  localparam logic [REG_AW-1:0] A_RX_ST = 6'h08;
  localparam logic [REG_AW-1:0] A_TX_EN = 6'h0D;
  localparam logic [REG_AW-1:0] A_TX_ST = 6'h0E;
  localparam logic [REG_AW-1:0] A_WK_EN = 6'h1C;
  localparam logic [REG_AW-1:0] A_WK_ST = 6'h1D;

  typedef enum logic [1:0] {
    CHIP_STD   = 2'd0,
    CHIP_64    = 2'd1,
    CHIP_32DDR = 2'd2,
    CHIP_ALT   = 2'd3
  } chip_mode_e;

  // lane B is unused in the single-lane chip rates
  function automatic logic lane_b_silenced(input chip_mode_e m);
    return (m == CHIP_64) || (m == CHIP_32DDR);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;
  logic         upd;

  // a fresh event outranks a clear in the same cycle
  always_comb begin
    flag_d = set_i | (clr_i ? '0 : flag_q);
    upd    = clr_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_wake_detect.sv
module irq_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic osc_ready,
  output logic rise_o
);
  logic osc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_q <= 1'b0;
    else        osc_q <= osc_ready;
  end

  assign rise_o = osc_ready & ~osc_q & pd_n;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic req_i,
  input  logic active_high_i,
  output logic pin_data_o,
  output logic pin_oe_o
);
  // the pin is only ever driven toward its asserted level
  assign pin_oe_o   = req_i;
  assign pin_data_o = active_high_i;
endmodule

// File: rtl/radio_irq_agg.sv
module radio_irq_agg
  import radio_irq_pkg::*;
#(
  parameter int unsigned TX_N   = 4,
  parameter int unsigned LANE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [LANE_N-1:0] rx_evt_a,
  input  logic [LANE_N-1:0] rx_evt_b,
  input  logic              tx_mode,
  input  logic [1:0]        chip_mode,
  input  logic              pd_n,
  input  logic              osc_ready,
  output logic              irq_data,
  output logic              irq_oe
);
  localparam int unsigned RX_N = 2 * LANE_N;

  logic              rst_s_n;
  logic [RX_N-1:0]   rx_en, rx_en_d, rx_stat, rx_set, rx_lane_mask;
  logic [TX_N-1:0]   tx_en, tx_en_d, tx_stat;
  logic              wake_en, wake_en_d, wake_stat, wake_rise;
  logic              cfg_high, cfg_high_d;
  logic [REG_DW-1:0] rd_val, rdata_q;
  logic              clr_rx, clr_tx, clr_wk, lane_b_off, req;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign lane_b_off = lane_b_silenced(chip_mode_e'(chip_mode));

  // per-lane gating: lane A always live, lane B off in single-lane rates
  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == 0) begin : g_a
      assign rx_set[LANE_N-1:0]       = rx_evt_a;
      assign rx_lane_mask[LANE_N-1:0] = '1;
    end else begin : g_b
      assign rx_set[RX_N-1:LANE_N]       = rx_evt_b & {LANE_N{~lane_b_off}};
      assign rx_lane_mask[RX_N-1:LANE_N] = {LANE_N{~lane_b_off}};
    end
  end

  // clear-on-read strobes
  always_comb begin
    clr_rx = reg_rd && (reg_addr == A_RX_ST);
    clr_tx = reg_rd && (reg_addr == A_TX_ST);
    clr_wk = reg_rd && (reg_addr == A_WK_ST);
  end

  irq_flag_bank #(.W(RX_N)) u_rx_flags (
    .clk(clk), .rst_n(rst_s_n), .set_i(rx_set), .clr_i(clr_rx), .flag_o(rx_stat)
  );

  irq_flag_bank #(.W(TX_N)) u_tx_flags (
    .clk(clk), .rst_n(rst_s_n), .set_i(tx_evt), .clr_i(clr_tx), .flag_o(tx_stat)
  );

  irq_wake_detect u_wake_det (
    .clk(clk), .rst_n(rst_s_n), .pd_n(pd_n), .osc_ready(osc_ready), .rise_o(wake_rise)
  );

  irq_flag_bank #(.W(1)) u_wk_flag (
    .clk(clk), .rst_n(rst_s_n), .set_i(wake_rise), .clr_i(clr_wk), .flag_o(wake_stat)
  );

  // enable and config next state
  always_comb begin
    rx_en_d    = rx_en;
    tx_en_d    = tx_en;
    wake_en_d  = wake_en;
    cfg_high_d = cfg_high;
    unique case (reg_addr)
      A_RX_EN: rx_en_d    = reg_wdata[RX_N-1:0];
      A_TX_EN: tx_en_d    = reg_wdata[TX_N-1:0];
      A_WK_EN: wake_en_d  = reg_wdata[0];
      A_CFG:   cfg_high_d = reg_wdata[0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rx_en    <= '0;
      tx_en    <= '0;
      wake_en  <= 1'b0;
      cfg_high <= 1'b0;
    end else if (reg_wr) begin
      rx_en    <= rx_en_d;
      tx_en    <= tx_en_d;
      wake_en  <= wake_en_d;
      cfg_high <= cfg_high_d;
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    unique case (reg_addr)
      A_CFG:   rd_val[0]        = cfg_high;
      A_RX_EN: rd_val[RX_N-1:0] = rx_en;
      A_RX_ST: rd_val[RX_N-1:0] = rx_stat;
      A_TX_EN: rd_val[TX_N-1:0] = tx_en;
      A_TX_ST: rd_val[TX_N-1:0] = tx_stat;
      A_WK_EN: rd_val[0]        = wake_en;
      A_WK_ST: rd_val[0]        = wake_stat;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_val;
  end

  assign reg_rdata = rdata_q;

  // request: enabled, not direction-masked, not lane-masked
  always_comb begin
    req = (|(tx_stat & tx_en & {TX_N{tx_mode}}))
        | (|(rx_stat & rx_en & rx_lane_mask & {RX_N{~tx_mode}}))
        | (wake_stat & wake_en);
  end

  irq_pin_drive u_pin (
    .req_i(req), .active_high_i(cfg_high), .pin_data_o(irq_data), .pin_oe_o(irq_oe)
  );
endmodule

// File: rtl/radio_irq_chk.sv
module radio_irq_chk
  import radio_irq_pkg::*;
#(
  parameter int unsigned TX_N = 4,
  parameter int unsigned RX_N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              tx_mode,
  input logic [1:0]        chip_mode,
  input logic              osc_ready,
  input logic [TX_N-1:0]   tx_evt,
  input logic              irq_oe,
  input logic              irq_data,
  input logic [TX_N-1:0]   tx_stat,
  input logic [RX_N-1:0]   rx_stat,
  input logic              wake_stat,
  input logic [TX_N-1:0]   tx_en,
  input logic [RX_N-1:0]   rx_en,
  input logic              wake_en,
  input logic              cfg_high
);
  localparam int unsigned HALF = RX_N / 2;

  // R8
  pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (irq_data == cfg_high));

  // R3
  tx_side_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && ((tx_stat & tx_en) == '0) && !(wake_stat && wake_en)) |-> !irq_oe);

  // R3
  rx_side_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && ((rx_stat & rx_en) == '0) && !(wake_stat && wake_en)) |-> !irq_oe);

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(rx_en) && $stable(tx_en) && $stable(wake_en) && $stable(cfg_high)));

  // R2
  event_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_evt) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt)));

  // R5
  lane_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((chip_mode == 2'd1) || (chip_mode == 2'd2)) && (rx_stat[RX_N-1:HALF] == '0))
      |=> (rx_stat[RX_N-1:HALF] == '0));

  // R7
  wake_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == A_WK_ST) && !osc_ready) |=> !wake_stat);

  // R9
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && (reg_addr == A_TX_ST) && (tx_evt == '0)) |=> $stable(tx_stat));
endmodule

bind radio_irq_agg radio_irq_chk #(.TX_N(TX_N), .RX_N(RX_N)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .tx_mode(tx_mode), .chip_mode(chip_mode), .osc_ready(osc_ready), .tx_evt(tx_evt),
  .irq_oe(irq_oe), .irq_data(irq_data), .tx_stat(tx_stat), .rx_stat(rx_stat),
  .wake_stat(wake_stat), .tx_en(tx_en), .rx_en(rx_en), .wake_en(wake_en),
  .cfg_high(cfg_high)
);

// File: tb/sim_radio_irq_agg.sv
module sim_radio_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] tx_evt, rx_evt_a, rx_evt_b;
  logic       tx_mode;
  logic [1:0] chip_mode;
  logic       pd_n, osc_ready;
  logic       irq_data, irq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  radio_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt), .rx_evt_a(rx_evt_a),
    .rx_evt_b(rx_evt_b), .tx_mode(tx_mode), .chip_mode(chip_mode), .pd_n(pd_n),
    .osc_ready(osc_ready), .irq_data(irq_data), .irq_oe(irq_oe)
  );

  // {write, pad, addr[5:0], wdata[7:0], expected read[7:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 6'h07, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h07, 8'h00, 8'hFF},
    {1'b1, 1'b0, 6'h0D, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h0D, 8'h00, 8'h0F},
    {1'b1, 1'b0, 6'h1C, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h1C, 8'h00, 8'h01},
    {1'b1, 1'b0, 6'h05, 8'hFE, 8'h00}, {1'b0, 1'b0, 6'h05, 8'h00, 8'h00},
    {1'b1, 1'b0, 6'h08, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h08, 8'h00, 8'h00},
    {1'b1, 1'b0, 6'h0E, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h0E, 8'h00, 8'h00},
    {1'b1, 1'b0, 6'h1D, 8'hFF, 8'h00}, {1'b0, 1'b0, 6'h10, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] t, input logic [3:0] ra, input logic [3:0] rb);
    @(negedge clk);
    tx_evt = t; rx_evt_a = ra; rx_evt_b = rb;
    @(negedge clk);
    tx_evt = '0; rx_evt_a = '0; rx_evt_b = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    tx_evt = '0; rx_evt_a = '0; rx_evt_b = '0; tx_mode = 1'b1; chip_mode = 2'd0;
    pd_n = 1'b0; osc_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10", "irq_oe", irq_oe, 0);
    check("R10", "irq_data", irq_data, 0);
    rd(6'h07, d); check("R10", "rx enable", d, 0);
    rd(6'h05, d); check("R10", "config", d, 0);

    // R1 / R9 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) wr(VEC[i][21:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][21:16], d);
        if (VEC[i][21:16] == 6'h08 || VEC[i][21:16] == 6'h0E || VEC[i][21:16] == 6'h1D)
          check("R9", "status after write", d, VEC[i][7:0]);
        else
          check("R1", "register read", d, VEC[i][7:0]);
      end
    end

    // R3 receive event masked in transmit mode, R2 status still records
    pulse(4'h0, 4'h1, 4'h0);
    check("R3", "rx masked in tx mode", irq_oe, 0);
    rd(6'h08, d); check("R2", "rx status under mask", d, 8'h01);
    rd(6'h08, d); check("R2", "rx status cleared", d, 8'h00);

    // R3/R8 transmit event, R4 enables kept across mode switch
    pulse(4'h2, 4'h0, 4'h0);
    check("R3", "tx event raises irq", irq_oe, 1);
    check("R8", "active-low level", irq_data, 0);
    @(negedge clk); tx_mode = 1'b0;
    @(negedge clk); check("R3", "tx masked in rx mode", irq_oe, 0);
    rd(6'h0D, d); check("R4", "tx enable after switch", d, 8'h0F);
    rd(6'h07, d); check("R4", "rx enable after switch", d, 8'hFF);
    @(negedge clk); tx_mode = 1'b1;
    @(negedge clk); check("R3", "tx unmasked again", irq_oe, 1);
    rd(6'h0E, d); check("R2", "tx status read", d, 8'h02);
    check("R3", "irq drops after clear", irq_oe, 0);

    // R2 status without enable
    wr(6'h0D, 8'h00);
    pulse(4'h8, 4'h0, 4'h0);
    check("R2", "disabled tx no irq", irq_oe, 0);
    rd(6'h0E, d); check("R2", "disabled tx status", d, 8'h08);
    wr(6'h0D, 8'h0F);

    // R2 event in the read cycle wins
    pulse(4'h1, 4'h0, 4'h0);
    @(negedge clk);
    reg_addr = 6'h0E; reg_rd = 1'b1; tx_evt = 4'h1;
    @(negedge clk);
    reg_rd = 1'b0; tx_evt = '0;
    check("R2", "read data with race", reg_rdata, 8'h01);
    check("R2", "irq held by racing event", irq_oe, 1);
    rd(6'h0E, d); check("R2", "racing event kept", d, 8'h01);
    check("R2", "cleared after second read", irq_oe, 0);

    // R5 lane B silenced in single-lane rates
    @(negedge clk); tx_mode = 1'b0; chip_mode = 2'd1;
    pulse(4'h0, 4'h0, 4'hF);
    check("R5", "lane B irq mode 1", irq_oe, 0);
    rd(6'h08, d); check("R5", "lane B status mode 1", d, 8'h00);
    @(negedge clk); chip_mode = 2'd2;
    pulse(4'h0, 4'h0, 4'hF);
    rd(6'h08, d); check("R5", "lane B status mode 2", d, 8'h00);
    @(negedge clk); chip_mode = 2'd0;
    pulse(4'h0, 4'h0, 4'h2);
    check("R5", "lane B irq mode 0", irq_oe, 1);
    rd(6'h08, d); check("R5", "lane B status mode 0", d, 8'h20);
    check("R5", "lane B cleared", irq_oe, 0);

    // R8 active-high polarity
    wr(6'h05, 8'h01);
    pulse(4'h0, 4'h1, 4'h0);
    check("R8", "active-high oe", irq_oe, 1);
    check("R8", "active-high level", irq_data, 1);
    rd(6'h08, d);
    check("R8", "idle oe", irq_oe, 0);
    wr(6'h05, 8'h00);

    // R6 wake rise ignored in power-down, R7 clear on read
    @(negedge clk); tx_mode = 1'b1; osc_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(6'h1D, d); check("R6", "rise during power-down", d, 8'h00);
    @(negedge clk); osc_ready = 1'b0; pd_n = 1'b1;
    @(negedge clk); osc_ready = 1'b1;
    @(negedge clk);
    check("R6", "wake irq", irq_oe, 1);
    rd(6'h1D, d); check("R7", "wake status read", d, 8'h01);
    rd(6'h1D, d); check("R7", "wake status cleared", d, 8'h00);
    check("R7", "irq after wake clear", irq_oe, 0);

    done = 1'b1;
    finish_run();
  end
endmodule